// File: doc/BRIEF.md
# MII Transmit Symbol Encoder

This block sits at the transmit front of a 10/100 Ethernet transceiver. It samples MII-style transmit inputs on the transmit clock and presents one registered output word per clock, with a valid flag.

At 100 Mb/s the output is a stream of 5-bit code groups, with one code group on every cycle:
- a normal data nibble is mapped through the standard 4B/5B table;
- a nibble flagged as errored is replaced by the HALT code group;
- an idle cycle produces the all-ones code group;
- two raw modes carry a 5-bit code group directly from the transmit-error pin (as the top bit) and the four data pins.

At 10 Mb/s the block forwards data in one of two ways, and the transmit-error pin has no effect:
- in nibble mode it passes the whole nibble;
- in serial mode it passes one bit per clock, taken from the lowest data pin.

The serial-mode selection is captured from a strap pin during reset. A one-bit write port can change it afterwards.

The output stage is a single register. Every result appears one clock after its inputs are sampled.

Top module: `mii_tx_symbol_enc`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_serial` and `out_sym` are cleared at each clock edge. `ser_mode` takes the value of `ser_strap` at each clock edge of reset.
- R2: At 100 Mb/s with no raw mode selected, a cycle with `tx_en`=1 and `tx_er`=0 gives `out_valid`=1 on the next clock, and `out_sym` is the 4B/5B group of `txd` (bit 0 is the LSB). The groups for nibbles 0 to F are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R3: At 100 Mb/s with the aligned raw mode off, a cycle with `tx_en`=0 gives `out_valid`=1 and `out_sym`=11111 on the next clock.
- R4: At 100 Mb/s with no raw mode selected, `tx_en`=1 together with `tx_er`=1 gives `out_sym`=00100 (HALT) on the next clock, whatever the value of `txd`.
- R5: At 100 Mb/s with `byp_code`=1 and `byp_align`=0, a cycle with `tx_en`=1 gives `out_sym`={`tx_er`,`txd`} unencoded. A cycle with `tx_en`=0 gives 11111.
- R6: At 100 Mb/s with `byp_align`=1, every cycle gives `out_valid`=1 and `out_sym`={`tx_er`,`txd`}, whatever the value of `tx_en`. This mode takes priority over `byp_code`.
- R7: At 10 Mb/s with `ser_mode`=0, `out_valid` equals `tx_en` one clock later. `out_sym` is {0,`txd`} and `out_serial`=0. `tx_er`, `byp_code` and `byp_align` have no effect.
- R8: At 10 Mb/s with `ser_mode`=1, `out_valid` equals `tx_en` one clock later, `out_serial`=1 and `out_sym`={0000,`txd[0]`}. `txd[3:1]` is ignored, and the bits leave in the order they were presented.
- R9: Outside reset, `ser_wr`=1 loads `ser_wdata` into `ser_mode` at the next clock. `ser_mode` has no effect on the output at 100 Mb/s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| byp_code | input | 1 | Raw code group mode, gated by tx_en |
| byp_align | input | 1 | Raw code group mode, every cycle |
| ser_strap | input | 1 | Serial-mode strap, captured in reset |
| ser_wr | input | 1 | Write strobe for the serial-mode bit |
| ser_wdata | input | 1 | Value written to the serial-mode bit |
| tx_en | input | 1 | Transmit enable |
| tx_er | input | 1 | Transmit error, or code group MSB in raw modes |
| txd | input | 4 | Transmit data nibble |
| out_valid | output | 1 | Output word is valid |
| out_sym | output | 5 | Code group, nibble or serial bit |
| out_serial | output | 1 | Output carries a serial bit in bit 0 |
| ser_mode | output | 1 | Current serial-mode bit |

## Verification
The bench builds the block with its default widths: a 4-bit nibble and a 5-bit code group. These widths keep the input space small enough to drive in full. All 16 data nibbles are checked against the table. All 32 raw code groups are checked in the gated raw mode. HALT substitution is checked across several nibble values. A serial byte is checked bit by bit with the unused data pins toggling, so the bit order and the ignored pins are both observed.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;
    localparam int NIB_W  = 4;
    localparam int CODE_W = NIB_W + 1;

    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [CODE_W-1:0] code_t;

    localparam code_t HALT_CODE = 5'b00100;
    localparam code_t IDLE_CODE = 5'b11111;

    typedef enum logic [2:0] {
        P_IDLE,
        P_DATA,
        P_HALT,
        P_RAW,
        P_NIB_OFF,
        P_NIB,
        P_SER
    } path_e;

    typedef struct packed {
        logic  vld;
        logic  ser;
        code_t sym;
    } out_s;

    function automatic code_t enc_4b5b(nib_t n);
        code_t c;
        case (n)
            4'h0: c = 5'b11110;
            4'h1: c = 5'b01001;
            4'h2: c = 5'b10100;
            4'h3: c = 5'b10101;
            4'h4: c = 5'b01010;
            4'h5: c = 5'b01011;
            4'h6: c = 5'b01110;
            4'h7: c = 5'b01111;
            4'h8: c = 5'b10010;
            4'h9: c = 5'b10011;
            4'hA: c = 5'b10110;
            4'hB: c = 5'b10111;
            4'hC: c = 5'b11010;
            4'hD: c = 5'b11011;
            4'hE: c = 5'b11100;
            default: c = 5'b11101;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/mii_tx_ser_reg.sv
module mii_tx_ser_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic strap,
    input  logic wr,
    input  logic wdata,
    output logic ser
);
    logic ser_d, ser_q;

    always_comb begin
        ser_d = ser_q;
        if (!rst_n)  ser_d = strap;
        else if (wr) ser_d = wdata;
    end

    always_ff @(posedge clk) begin
        ser_q <= ser_d;
    end

    assign ser = ser_q;
endmodule

// File: rtl/mii_tx_path_dec.sv
module mii_tx_path_dec
    import mii_tx_pkg::*;
(
    input  logic  speed_100,
    input  logic  ser_mode,
    input  logic  byp_code,
    input  logic  byp_align,
    input  logic  tx_en,
    input  logic  tx_er,
    output path_e path
);
    always_comb begin
        path = P_IDLE;
        if (speed_100) begin
            if (byp_align)      path = P_RAW;
            else if (!tx_en)    path = P_IDLE;
            else if (byp_code)  path = P_RAW;
            else if (tx_er)     path = P_HALT;
            else                path = P_DATA;
        end else begin
            if (!tx_en)         path = P_NIB_OFF;
            else if (ser_mode)  path = P_SER;
            else                path = P_NIB;
        end
    end
endmodule

// File: rtl/mii_tx_sym_mux.sv
module mii_tx_sym_mux
    import mii_tx_pkg::*;
(
    input  path_e path,
    input  logic  tx_er,
    input  nib_t  txd,
    output out_s  word
);
    always_comb begin
        word = '0;
        case (path)
            P_IDLE:  begin word.vld = 1'b1; word.sym = IDLE_CODE; end
            P_DATA:  begin word.vld = 1'b1; word.sym = enc_4b5b(txd); end
            P_HALT:  begin word.vld = 1'b1; word.sym = HALT_CODE; end
            P_RAW:   begin word.vld = 1'b1; word.sym = {tx_er, txd}; end
            P_NIB:   begin word.vld = 1'b1; word.sym = {1'b0, txd}; end
            P_SER:   begin
                word.vld = 1'b1;
                word.ser = 1'b1;
                word.sym = {{(CODE_W-1){1'b0}}, txd[0]};
            end
            default: word = '0;
        endcase
    end
endmodule

// File: rtl/mii_tx_symbol_enc.sv
module mii_tx_symbol_enc
    import mii_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              speed_100,
    input  logic              byp_code,
    input  logic              byp_align,
    input  logic              ser_strap,
    input  logic              ser_wr,
    input  logic              ser_wdata,
    input  logic              tx_en,
    input  logic              tx_er,
    input  logic [NIB_W-1:0]  txd,
    output logic              out_valid,
    output logic [CODE_W-1:0] out_sym,
    output logic              out_serial,
    output logic              ser_mode
);
    path_e path;
    out_s  word;
    out_s  out_d, out_q;

    mii_tx_ser_reg u_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .strap (ser_strap),
        .wr    (ser_wr),
        .wdata (ser_wdata),
        .ser   (ser_mode)
    );

    mii_tx_path_dec u_dec (
        .speed_100 (speed_100),
        .ser_mode  (ser_mode),
        .byp_code  (byp_code),
        .byp_align (byp_align),
        .tx_en     (tx_en),
        .tx_er     (tx_er),
        .path      (path)
    );

    mii_tx_sym_mux u_mux (
        .path  (path),
        .tx_er (tx_er),
        .txd   (txd),
        .word  (word)
    );

    always_comb begin
        out_d = word;
        if (!rst_n) out_d = '0;
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign out_valid  = out_q.vld;
    assign out_sym    = out_q.sym;
    assign out_serial = out_q.ser;
endmodule

// File: rtl/mii_tx_symbol_enc_chk.sv
module mii_tx_symbol_enc_chk
    import mii_tx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              speed_100,
    input logic              byp_code,
    input logic              byp_align,
    input logic              ser_strap,
    input logic              ser_wr,
    input logic              ser_wdata,
    input logic              tx_en,
    input logic              tx_er,
    input logic [NIB_W-1:0]  txd,
    input logic              out_valid,
    input logic [CODE_W-1:0] out_sym,
    input logic              out_serial,
    input logic              ser_mode
);
    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> !out_valid && !out_serial); // R1
    AST_HALT_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        speed_100 && !byp_align && !byp_code && tx_en && tx_er |=> out_valid && out_sym == HALT_CODE); // R4
    AST_IDLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        speed_100 && !byp_align && !tx_en |=> out_valid && out_sym == IDLE_CODE); // R3
    AST_ALIGN_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        speed_100 && byp_align |=> out_valid && out_sym == {$past(tx_er), $past(txd)}); // R6
    AST_SLOW_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !speed_100 |=> out_valid == $past(tx_en)); // R7
    AST_SER_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        !speed_100 && ser_mode && tx_en |=> out_serial && out_sym[CODE_W-1:1] == '0); // R8
    AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ser_wr |=> ser_mode == $past(ser_wdata)); // R9
endmodule

bind mii_tx_symbol_enc mii_tx_symbol_enc_chk u_chk (.*);

// File: tb/mii_tx_symbol_enc_test.sv
module mii_tx_symbol_enc_test;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       speed_100 = 1'b1, byp_code = 1'b0, byp_align = 1'b0;
    logic       ser_strap = 1'b0, ser_wr = 1'b0, ser_wdata = 1'b0;
    logic       tx_en = 1'b0, tx_er = 1'b0;
    logic [3:0] txd = 4'h0;
    logic       out_valid, out_serial, ser_mode;
    logic [4:0] out_sym;

    int n_chk = 0;
    int n_err = 0;

    always #(PERIOD/2) clk = ~clk;

    mii_tx_symbol_enc uut (
        .clk(clk), .rst_n(rst_n), .speed_100(speed_100), .byp_code(byp_code),
        .byp_align(byp_align), .ser_strap(ser_strap), .ser_wr(ser_wr),
        .ser_wdata(ser_wdata), .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
        .out_valid(out_valid), .out_sym(out_sym), .out_serial(out_serial),
        .ser_mode(ser_mode)
    );

    function automatic logic [4:0] ref_grp(logic [3:0] n);
        logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                               5'b01010, 5'b01011, 5'b01110, 5'b01111,
                               5'b10010, 5'b10011, 5'b10110, 5'b10111,
                               5'b11010, 5'b11011, 5'b11100, 5'b11101};
        return t[n];
    endfunction

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive one cycle of inputs, then sample just after the capturing edge.
    task automatic step(logic en, logic er, logic [3:0] d);
        tx_en = en; tx_er = er; txd = d;
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; ser_strap = 1'b1; step(1'b1, 1'b0, 4'h3); step(1'b1, 1'b0, 4'h3);
        check("R1 valid in reset", {7'd0, out_valid}, 8'd0);
        check("R1 strap high", {7'd0, ser_mode}, 8'd1);
        ser_strap = 1'b0; step(1'b1, 1'b0, 4'h3);
        check("R1 strap low", {7'd0, ser_mode}, 8'd0);
        rst_n = 1'b1; ser_strap = 1'b1; step(1'b0, 1'b0, 4'h0);
        check("R1 strap ignored after reset", {7'd0, ser_mode}, 8'd0);
    endtask

    task automatic t_data();
        speed_100 = 1'b1;
        for (int i = 0; i < 16; i++) begin
            step(1'b1, 1'b0, 4'(i));
            check("R2 data group", {2'b0, out_valid, out_sym}, {3'b001, ref_grp(4'(i))});
        end
    endtask

    task automatic t_idle();
        step(1'b0, 1'b1, 4'h5);
        check("R3 idle", {2'b0, out_valid, out_sym}, 8'h3F);
    endtask

    task automatic t_halt();
        for (int i = 0; i < 16; i += 5) begin
            step(1'b1, 1'b1, 4'(i));
            check("R4 halt", {2'b0, out_valid, out_sym}, {3'b001, 5'b00100});
        end
    endtask

    task automatic t_byp_code();
        byp_code = 1'b1;
        for (int i = 0; i < 32; i++) begin
            step(1'b1, i[4], i[3:0]);
            check("R5 raw", {3'b0, out_sym}, 8'(i));
        end
        step(1'b0, 1'b0, 4'h2);
        check("R5 raw idle", {3'b0, out_sym}, 8'h1F);
        byp_code = 1'b0;
    endtask

    task automatic t_byp_align();
        byp_align = 1'b1;
        step(1'b0, 1'b0, 4'h4);
        check("R6 align no enable", {2'b0, out_valid, out_sym}, 8'h24);
        byp_code = 1'b1;
        step(1'b1, 1'b1, 4'h0);
        check("R6 align priority", {3'b0, out_sym}, 8'h10);
        byp_code = 1'b0; byp_align = 1'b0;
    endtask

    task automatic t_nib10();
        speed_100 = 1'b0; byp_align = 1'b1;
        step(1'b1, 1'b1, 4'h9);
        check("R7 nibble with er", {1'b0, out_serial, out_valid, out_sym}, 8'h29);
        step(1'b0, 1'b0, 4'h9);
        check("R7 nibble idle", {7'b0, out_valid}, 8'd0);
        byp_align = 1'b0;
    endtask

    task automatic t_serial();
        logic [7:0] b = 8'hA5;
        ser_wr = 1'b1; ser_wdata = 1'b1; step(1'b0, 1'b0, 4'h0); ser_wr = 1'b0;
        check("R9 write sets serial", {7'b0, ser_mode}, 8'd1);
        for (int i = 0; i < 8; i++) begin
            step(1'b1, 1'b1, {3'(7 - i), b[i]});
            check("R8 serial bit", {1'b0, out_serial, out_valid, out_sym}, {6'b011000, 1'b0, b[i]});
        end
        speed_100 = 1'b1;
        step(1'b1, 1'b0, 4'h7);
        check("R9 serial no effect at 100", {1'b0, out_serial, out_valid, out_sym}, {3'b001, ref_grp(4'h7)});
        ser_wr = 1'b1; ser_wdata = 1'b0; step(1'b0, 1'b0, 4'h0); ser_wr = 1'b0;
        check("R9 write clears serial", {7'b0, ser_mode}, 8'd0);
    endtask

    initial begin
        #(PERIOD * 100000);
        n_err++; n_chk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_data();
        t_idle();
        t_halt();
        t_byp_code();
        t_byp_align();
        t_nib10();
        t_serial();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule